// File: doc/BRIEF.md
# Serial Controller Register Bank

This block is the processor-side register interface of an asynchronous serial controller. A processor presents a 3-bit offset together with read and write strobes and an 8-bit data bus. The block decodes each access to one of eleven registers and stores the control registers. It passes status bytes from the rest of the controller back onto the read bus. It also gives one-cycle pulses that tell the transmitter that a new character is waiting, and tell the receiver that its held character has been taken.

Offsets 0 and 1 change meaning with bit 7 of the line control register, called the divisor access bit here. When that bit is clear, offset 0 is the received character on reads and the transmit holding byte on writes, and offset 1 is the interrupt enable byte. When the bit is set, offsets 0 and 1 are the low and high halves of the 16-bit baud divisor. Offsets 2 to 7 decode the same way whatever the access bit holds. The transmit holding byte is stored separately from any shift register, and the received byte arrives as a held input. The processor can therefore read and write characters while serial conversion is running.

Top module: `uart_regbank`

## Requirements
- R1: While reset is asserted and after it is released, line control, interrupt enable, modem control, the divisor, the transmit holding byte and the read data are all zero, and neither pulse is high.
- R2: With the access bit (line_ctl[7]) clear, a read at offset 0 returns rx_data on rdata one cycle later, and rx_unload is high for exactly that one cycle.
- R3: With the access bit clear, a write at offset 0 places the byte on tx_hold one cycle later, and tx_load is high for exactly that one cycle. The divisor does not change.
- R4: With the access bit clear, offset 1 writes and reads back the interrupt enable byte (int_en).
- R5: With the access bit set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. These accesses raise neither pulse and leave tx_hold and int_en unchanged.
- R6: Offset 3 (line control) and offset 4 (modem control) write and read back whatever the access bit holds. The access bit is line_ctl[7].
- R7: Reads at offsets 2, 5 and 6 return int_id, line_stat and modem_stat. Writes to those offsets change no output.
- R8: Offset 7 stores any byte and returns it on a read. A write there changes no other output.
- R9: rdata keeps its value in every cycle that has no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Character held by the receiver |
| int_id | input | 8 | Interrupt identification byte |
| line_stat | input | 8 | Line status byte |
| modem_stat | input | 8 | Modem status byte |
| tx_hold | output | 8 | Transmit holding byte |
| tx_load | output | 1 | Pulse: new transmit byte loaded |
| rx_unload | output | 1 | Pulse: received byte read |
| int_en | output | 8 | Interrupt enable byte |
| line_ctl | output | 8 | Line control byte |
| modem_ctl | output | 8 | Modem control byte |
| divisor | output | 16 | Baud divisor |

## Verification
On every cycle, the assertions check the following: that each pulse follows exactly the access that should cause it, with the right data, that the divisor stays fixed unless a divisor-mode write occurs, that writes to the read-only offsets leave every control output unchanged, and that rdata holds between reads. Other behaviour needs the bench's scenarios, because each of these depends on a whole sequence of accesses. The reset values and the scratch byte's round trip are two examples. Another is how offsets 0 and 1 switch meaning only after a line control write has set or cleared the access bit. A further example is the readback of each divisor half.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int BANK_DW = 8;
    localparam int BANK_AW = 3;
    localparam int DIV_W   = 2 * BANK_DW;
    localparam int ACC_BIT = BANK_DW - 1;

    typedef enum logic [3:0] {
        SEL_DATA,
        SEL_IEN,
        SEL_IID,
        SEL_LCTL,
        SEL_MCTL,
        SEL_LSTAT,
        SEL_MSTAT,
        SEL_SCRATCH,
        SEL_DIV_LO,
        SEL_DIV_HI
    } reg_sel_e;

    typedef struct packed {
        logic [BANK_DW-1:0] lctl;
        logic [BANK_DW-1:0] ien;
        logic [BANK_DW-1:0] mctl;
        logic [BANK_DW-1:0] scratch;
        logic [BANK_DW-1:0] div_lo;
        logic [BANK_DW-1:0] div_hi;
        logic [BANK_DW-1:0] thold;
        logic [BANK_DW-1:0] rbus;
        logic               load_p;
        logic               unload_p;
    } bank_t;

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
    import uart_regbank_pkg::*;
(
    input  logic [BANK_AW-1:0] addr,
    input  logic               acc_bit,
    output reg_sel_e           sel
);

    always_comb begin
        unique case (addr)
            3'd0:    sel = acc_bit ? SEL_DIV_LO : SEL_DATA;
            3'd1:    sel = acc_bit ? SEL_DIV_HI : SEL_IEN;
            3'd2:    sel = SEL_IID;
            3'd3:    sel = SEL_LCTL;
            3'd4:    sel = SEL_MCTL;
            3'd5:    sel = SEL_LSTAT;
            3'd6:    sel = SEL_MSTAT;
            default: sel = SEL_SCRATCH;
        endcase
    end

endmodule

// File: rtl/uart_regbank_rdmux.sv
module uart_regbank_rdmux
    import uart_regbank_pkg::*;
(
    input  reg_sel_e           sel,
    input  bank_t              bank,
    input  logic [BANK_DW-1:0] rx_data,
    input  logic [BANK_DW-1:0] int_id,
    input  logic [BANK_DW-1:0] line_stat,
    input  logic [BANK_DW-1:0] modem_stat,
    output logic [BANK_DW-1:0] rd_value
);

    always_comb begin
        unique case (sel)
            SEL_DATA:    rd_value = rx_data;
            SEL_IEN:     rd_value = bank.ien;
            SEL_IID:     rd_value = int_id;
            SEL_LCTL:    rd_value = bank.lctl;
            SEL_MCTL:    rd_value = bank.mctl;
            SEL_LSTAT:   rd_value = line_stat;
            SEL_MSTAT:   rd_value = modem_stat;
            SEL_SCRATCH: rd_value = bank.scratch;
            SEL_DIV_LO:  rd_value = bank.div_lo;
            SEL_DIV_HI:  rd_value = bank.div_hi;
            default:     rd_value = '0;
        endcase
    end

endmodule

// File: rtl/uart_regbank_store.sv
module uart_regbank_store
    import uart_regbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  reg_sel_e           sel,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [BANK_DW-1:0] wdata,
    input  logic [BANK_DW-1:0] rd_value,
    output bank_t              bank_q
);

    bank_t bank_d;

    always_comb begin
        bank_d          = bank_q;
        bank_d.load_p   = 1'b0;
        bank_d.unload_p = 1'b0;

        if (wr_en) begin
            unique case (sel)
                SEL_DATA: begin
                    bank_d.thold  = wdata;
                    bank_d.load_p = 1'b1;
                end
                SEL_IEN:     bank_d.ien     = wdata;
                SEL_LCTL:    bank_d.lctl    = wdata;
                SEL_MCTL:    bank_d.mctl    = wdata;
                SEL_SCRATCH: bank_d.scratch = wdata;
                SEL_DIV_LO:  bank_d.div_lo  = wdata;
                SEL_DIV_HI:  bank_d.div_hi  = wdata;
                default:     ; // status offsets are read only
            endcase
        end

        if (rd_en) begin
            bank_d.rbus = rd_value;
            if (sel == SEL_DATA) begin
                bank_d.unload_p = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_AW-1:0]   addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [BANK_DW-1:0]   wdata,
    output logic [BANK_DW-1:0]   rdata,
    input  logic [BANK_DW-1:0]   rx_data,
    input  logic [BANK_DW-1:0]   int_id,
    input  logic [BANK_DW-1:0]   line_stat,
    input  logic [BANK_DW-1:0]   modem_stat,
    output logic [BANK_DW-1:0]   tx_hold,
    output logic                 tx_load,
    output logic                 rx_unload,
    output logic [BANK_DW-1:0]   int_en,
    output logic [BANK_DW-1:0]   line_ctl,
    output logic [BANK_DW-1:0]   modem_ctl,
    output logic [DIV_W-1:0]     divisor
);

    reg_sel_e           sel;
    bank_t              bank;
    logic [BANK_DW-1:0] rd_value;

    uart_regbank_decode u_decode (
        .addr    (addr),
        .acc_bit (bank.lctl[ACC_BIT]),
        .sel     (sel)
    );

    uart_regbank_rdmux u_rdmux (
        .sel        (sel),
        .bank       (bank),
        .rx_data    (rx_data),
        .int_id     (int_id),
        .line_stat  (line_stat),
        .modem_stat (modem_stat),
        .rd_value   (rd_value)
    );

    uart_regbank_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .rd_value (rd_value),
        .bank_q   (bank)
    );

    assign rdata     = bank.rbus;
    assign tx_hold   = bank.thold;
    assign tx_load   = bank.load_p;
    assign rx_unload = bank.unload_p;
    assign int_en    = bank.ien;
    assign line_ctl  = bank.lctl;
    assign modem_ctl = bank.mctl;
    assign divisor   = {bank.div_hi, bank.div_lo};

endmodule

// File: rtl/uart_regbank_checker.sv
module uart_regbank_checker
    import uart_regbank_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [BANK_AW-1:0] addr,
    input logic               rd_en,
    input logic               wr_en,
    input logic [BANK_DW-1:0] wdata,
    input logic [BANK_DW-1:0] rdata,
    input logic [BANK_DW-1:0] rx_data,
    input logic [BANK_DW-1:0] tx_hold,
    input logic               tx_load,
    input logic               rx_unload,
    input logic [BANK_DW-1:0] int_en,
    input logic [BANK_DW-1:0] line_ctl,
    input logic [BANK_DW-1:0] modem_ctl,
    input logic [DIV_W-1:0]   divisor
);

    logic acc;
    logic data_wr, data_rd, div_wr, ro_wr;

    assign acc     = line_ctl[ACC_BIT];
    assign data_wr = wr_en && addr == 3'd0 && !acc;
    assign data_rd = rd_en && addr == 3'd0 && !acc;
    assign div_wr  = wr_en && addr[2:1] == 2'b00 && acc;
    assign ro_wr   = wr_en && (addr == 3'd2 || addr == 3'd5 || addr == 3'd6);

    // R1: reset clears the control state
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (line_ctl == '0 && int_en == '0 && modem_ctl == '0
                    && divisor == '0 && !tx_load && !rx_unload));

    // R2: receive read gives data and an unload pulse
    a_r2_unload_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> (rx_unload && rdata == $past(rx_data)));

    a_r2_unload_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd |=> !rx_unload);

    // R3: transmit write gives data and a load pulse
    a_r3_load_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (tx_load && tx_hold == $past(wdata)));

    a_r3_load_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> !tx_load);

    // R5: divisor moves only on a divisor-mode write
    a_r5_divisor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !div_wr |=> $stable(divisor));

    // R7: writes to status offsets change nothing
    a_r7_ro_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        ro_wr |=> ($stable(line_ctl) && $stable(int_en) && $stable(modem_ctl)
                   && $stable(divisor) && $stable(tx_hold)));

    // R9: read data holds without a read
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind uart_regbank uart_regbank_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .rx_data   (rx_data),
    .tx_hold   (tx_hold),
    .tx_load   (tx_load),
    .rx_unload (rx_unload),
    .int_en    (int_en),
    .line_ctl  (line_ctl),
    .modem_ctl (modem_ctl),
    .divisor   (divisor)
);

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  rx_data = '0;
    logic [7:0]  int_id = '0;
    logic [7:0]  line_stat = '0;
    logic [7:0]  modem_stat = '0;
    logic [7:0]  tx_hold;
    logic        tx_load;
    logic        rx_unload;
    logic [7:0]  int_en;
    logic [7:0]  line_ctl;
    logic [7:0]  modem_ctl;
    logic [15:0] divisor;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_regbank uut (
        .clk (clk), .rst_n (rst_n), .addr (addr), .rd_en (rd_en), .wr_en (wr_en),
        .wdata (wdata), .rdata (rdata), .rx_data (rx_data), .int_id (int_id),
        .line_stat (line_stat), .modem_stat (modem_stat), .tx_hold (tx_hold),
        .tx_load (tx_load), .rx_unload (rx_unload), .int_en (int_en),
        .line_ctl (line_ctl), .modem_ctl (modem_ctl), .divisor (divisor)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // strobe held across one rising edge; returns at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 line_ctl", {8'h0, line_ctl}, 16'h0);
        chk("R1 int_en", {8'h0, int_en}, 16'h0);
        chk("R1 modem_ctl", {8'h0, modem_ctl}, 16'h0);
        chk("R1 divisor", divisor, 16'h0);
        chk("R1 tx_hold", {8'h0, tx_hold}, 16'h0);
        chk("R1 rdata", {8'h0, rdata}, 16'h0);
        chk("R1 pulses", {14'h0, tx_load, rx_unload}, 16'h0);
    endtask

    task automatic t_rx_read();
        rx_data = 8'hA5;
        rd(3'd0);
        chk("R2 rdata", {8'h0, rdata}, 16'h00A5);
        chk("R2 unload high", {15'h0, rx_unload}, 16'h1);
        @(negedge clk);
        chk("R2 unload one cycle", {15'h0, rx_unload}, 16'h0);
    endtask

    task automatic t_tx_write();
        wr(3'd0, 8'h3C);
        chk("R3 tx_hold", {8'h0, tx_hold}, 16'h003C);
        chk("R3 load high", {15'h0, tx_load}, 16'h1);
        chk("R3 divisor kept", divisor, 16'h0);
        @(negedge clk);
        chk("R3 load one cycle", {15'h0, tx_load}, 16'h0);
    endtask

    task automatic t_ien();
        wr(3'd1, 8'h0F);
        chk("R4 int_en", {8'h0, int_en}, 16'h000F);
        rd(3'd1);
        chk("R4 readback", {8'h0, rdata}, 16'h000F);
    endtask

    task automatic t_divisor();
        wr(3'd3, 8'h83);
        chk("R6 line_ctl", {8'h0, line_ctl}, 16'h0083);
        wr(3'd0, 8'h12);
        chk("R5 no load", {15'h0, tx_load}, 16'h0);
        wr(3'd1, 8'h34);
        chk("R5 divisor", divisor, 16'h3412);
        chk("R5 tx_hold kept", {8'h0, tx_hold}, 16'h003C);
        chk("R5 int_en kept", {8'h0, int_en}, 16'h000F);
        rd(3'd0);
        chk("R5 low read", {8'h0, rdata}, 16'h0012);
        chk("R5 no unload", {15'h0, rx_unload}, 16'h0);
        rd(3'd1);
        chk("R5 high read", {8'h0, rdata}, 16'h0034);
        rd(3'd3);
        chk("R6 lctl read with access bit", {8'h0, rdata}, 16'h0083);
        wr(3'd3, 8'h03);
        rx_data = 8'h6E;
        rd(3'd0);
        chk("R2 data again after clear", {8'h0, rdata}, 16'h006E);
    endtask

    task automatic t_status();
        int_id = 8'hC1; line_stat = 8'h60; modem_stat = 8'hB0;
        rd(3'd2);
        chk("R7 int_id", {8'h0, rdata}, 16'h00C1);
        rd(3'd5);
        chk("R7 line_stat", {8'h0, rdata}, 16'h0060);
        rd(3'd6);
        chk("R7 modem_stat", {8'h0, rdata}, 16'h00B0);
        for (int i = 0; i < 3; i++) begin
            wr(i == 0 ? 3'd2 : (i == 1 ? 3'd5 : 3'd6), 8'hFF);
            chk("R7 lctl kept", {8'h0, line_ctl}, 16'h0003);
            chk("R7 ien kept", {8'h0, int_en}, 16'h000F);
            chk("R7 mctl kept", {8'h0, modem_ctl}, 16'h0000);
            chk("R7 div kept", divisor, 16'h3412);
            chk("R7 thold kept", {8'h0, tx_hold}, 16'h003C);
            chk("R7 no load", {15'h0, tx_load}, 16'h0);
        end
    endtask

    task automatic t_mctl();
        wr(3'd4, 8'h1B);
        chk("R6 modem_ctl", {8'h0, modem_ctl}, 16'h001B);
        rd(3'd4);
        chk("R6 mctl read", {8'h0, rdata}, 16'h001B);
    endtask

    task automatic t_scratch();
        wr(3'd7, 8'h5A);
        chk("R8 no load", {15'h0, tx_load}, 16'h0);
        chk("R8 others kept", {line_ctl, int_en}, 16'h030F);
        chk("R8 div kept", divisor, 16'h3412);
        rd(3'd7);
        chk("R8 readback", {8'h0, rdata}, 16'h005A);
    endtask

    task automatic t_hold();
        rx_data = 8'h99;
        repeat (4) @(negedge clk);
        chk("R9 rdata held", {8'h0, rdata}, 16'h005A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_read();
        t_tx_write();
        t_ien();
        t_divisor();
        t_status();
        t_mctl();
        t_scratch();
        t_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule